// File: doc/BRIEF.md
# Cascadable Column Data Acquisition Register

This block gathers one display line of 6-bit sub-pixel codes for a column driver. Every clock delivers a word made of three codes. A single-hot enable token steps along an address register. At each position it writes the latched word into one group of three adjacent channels of the line register. Every channel code is available in parallel on a flat output bus, which feeds the conversion stage downstream.

A direction input sets the fill order, either ascending or descending, and decides which of the two enable pins listens and which one drives. Each pin has an output value and an output-enable. Only the pin that has the output role is ever enabled.

When the token leaves the last position it appears for one cycle on the output-role pin. A neighbouring driver that takes that pin as its start input then picks up the very next word without a gap. Between passes the block raises a standby flag. It holds that flag until a new start pulse arrives.

Top module: `cad_column_capture`

## Requirements
- R1: After reset every channel code is 0, `standby_o` is 1, `line_done_o` is 0 and both enable output values are 0.
- R2: When the block is in standby and the input-role enable pin is high at a rising edge, the token enters the first position and the data word is latched at that same edge. `standby_o` is 0 from that edge on.
- R3: A word is split into three fields, which go to the three channels of its group: bits 5..0 go to the lowest-numbered channel, bits 11..6 to the middle one and bits 17..12 to the highest. Group g (0-based) appears on `line_codes_o[18g +: 18]`.
- R4: With `fill_up_i` = 1, pin A is the input and pin B is the output (`en_b_oe_o` = 1, `en_a_oe_o` = 0). The word latched at the start edge lands in group 0, and each following word lands in the next higher group, one group per clock.
- R5: With `fill_up_i` = 0, the pin roles are swapped (`en_a_oe_o` = 1, `en_b_oe_o` = 0) and the fill runs from group GROUPS-1 down to group 0.
- R6: The output-role pin is high for exactly one cycle, from the (GROUPS-1)-th edge after the start edge to the GROUPS-th edge. A pin in the input role always drives 0.
- R7: `standby_o` stays 0 while the token is in flight. It rises at the GROUPS-th edge after the start edge and stays 1 until the next accepted start.
- R8: A start pulse that arrives while the token is in flight, including at the final write edge, is ignored. The pass runs to completion unchanged.
- R9: `line_done_o` is high for exactly the one cycle that follows the final group write.
- R10: A high level on the output-role pin does not start a pass. The block stays in standby and the line contents stay unchanged.
- R11: During a pass, any group not yet reached keeps the code it held from the previous line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| fill_up_i | input | 1 | 1: ascending fill with pin A as input; 0: descending fill with pin B as input |
| en_a_i | input | 1 | Enable pin A, input value |
| en_b_i | input | 1 | Enable pin B, input value |
| en_a_o | output | 1 | Enable pin A, driven value |
| en_a_oe_o | output | 1 | Enable pin A, output enable |
| en_b_o | output | 1 | Enable pin B, driven value |
| en_b_oe_o | output | 1 | Enable pin B, output enable |
| pix_word_i | input | LANES*CODE_W | Three sub-pixel codes for the current group |
| line_codes_o | output | GROUPS*LANES*CODE_W | All channel codes of the line register |
| standby_o | output | 1 | Low-power standby flag |
| line_done_o | output | 1 | One-cycle strobe after the last group write |

## Verification
The bench builds the block with GROUPS = 4 and keeps CODE_W = 6 and LANES = 3. A whole pass then takes only five edges. This lets every edge of the pass be compared with a model: the start edge, the partial fills in both directions, the single cycle of the exit pulse and the done strobe. A four-group line also puts the retrigger case at the final write edge and the check of unreached groups within a few cycles. Every lane carries a distinct field value, so a swapped field or a mirrored group shows up in the line bus.

// File: rtl/cad_pkg.sv
package cad_pkg;

  // Default geometry of one capture stage.
  localparam int CAD_CODE_W = 6;
  localparam int CAD_LANES  = 3;

  // Group index reached by token position pos when the fill runs downward.
  function automatic int mirror_pos(input int pos, input int groups);
    return groups - 1 - pos;
  endfunction

endpackage

// File: rtl/cad_token_ring.sv
module cad_token_ring #(
  parameter int GROUPS = 80
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  output logic [GROUPS-1:0] token_o,
  output logic              load_o,
  output logic              exit_o,
  output logic              standby_o,
  output logic              done_o
);

  localparam int LAST = GROUPS - 1;

  logic [GROUPS-1:0] token_q;
  logic [GROUPS-1:0] token_d;
  logic              busy;
  logic              accept;
  logic              standby_q;
  logic              done_q;

  assign busy    = |token_q;
  // A start pulse is only taken while no token is in flight.
  assign accept  = start_i & ~busy;
  assign token_d = {token_q[LAST-1:0], accept};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      token_q   <= '0;
      standby_q <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      token_q   <= token_d;
      standby_q <= ~|token_d;
      done_q    <= token_q[LAST];
    end
  end

  assign token_o   = token_q;
  assign load_o    = accept | busy;
  assign exit_o    = token_q[LAST];
  assign standby_o = standby_q;
  assign done_o    = done_q;

endmodule

// File: rtl/cad_word_latch.sv
module cad_word_latch #(
  parameter int WORD_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       word_q <= '0;
    else if (load_i) word_q <= word_i;
  end

  assign word_o = word_q;

endmodule

// File: rtl/cad_line_store.sv
module cad_line_store #(
  parameter int GROUPS = 80,
  parameter int WORD_W = 18
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     fill_up_i,
  input  logic [GROUPS-1:0]        token_i,
  input  logic [WORD_W-1:0]        word_i,
  output logic [GROUPS*WORD_W-1:0] line_o
);

  for (genvar g = 0; g < GROUPS; g++) begin : g_group
    localparam int POS_UP = g;
    localparam int POS_DN = cad_pkg::mirror_pos(g, GROUPS);

    logic              sel;
    logic [WORD_W-1:0] cell_q;

    assign sel = fill_up_i ? token_i[POS_UP] : token_i[POS_DN];

    always_ff @(posedge clk_i) begin
      if (rst_i)    cell_q <= '0;
      else if (sel) cell_q <= word_i;
    end

    assign line_o[g*WORD_W +: WORD_W] = cell_q;
  end

endmodule

// File: rtl/cad_column_capture.sv
module cad_column_capture #(
  parameter int GROUPS = 80,
  parameter int CODE_W = cad_pkg::CAD_CODE_W,
  parameter int LANES  = cad_pkg::CAD_LANES
) (
  input  logic                            clk_i,
  input  logic                            rst_i,
  input  logic                            fill_up_i,
  input  logic                            en_a_i,
  input  logic                            en_b_i,
  output logic                            en_a_o,
  output logic                            en_a_oe_o,
  output logic                            en_b_o,
  output logic                            en_b_oe_o,
  input  logic [LANES*CODE_W-1:0]         pix_word_i,
  output logic [GROUPS*LANES*CODE_W-1:0]  line_codes_o,
  output logic                            standby_o,
  output logic                            line_done_o
);

  localparam int WORD_W = LANES * CODE_W;

  logic              start;
  logic [GROUPS-1:0] token;
  logic              load;
  logic              exit_tok;
  logic [WORD_W-1:0] word_q;

  // Pin roles follow the fill direction.
  assign start     = fill_up_i ? en_a_i : en_b_i;
  assign en_a_oe_o = ~fill_up_i;
  assign en_b_oe_o = fill_up_i;
  assign en_a_o    = ~fill_up_i & exit_tok;
  assign en_b_o    = fill_up_i & exit_tok;

  cad_token_ring #(.GROUPS(GROUPS)) u_ring (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .start_i   (start),
    .token_o   (token),
    .load_o    (load),
    .exit_o    (exit_tok),
    .standby_o (standby_o),
    .done_o    (line_done_o)
  );

  cad_word_latch #(.WORD_W(WORD_W)) u_latch (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .load_i (load),
    .word_i (pix_word_i),
    .word_o (word_q)
  );

  cad_line_store #(.GROUPS(GROUPS), .WORD_W(WORD_W)) u_store (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .fill_up_i (fill_up_i),
    .token_i   (token),
    .word_i    (word_q),
    .line_o    (line_codes_o)
  );

endmodule

// File: rtl/cad_column_capture_chk.sv
module cad_column_capture_chk (
  input logic clk_i,
  input logic rst_i,
  input logic fill_up_i,
  input logic en_a_i,
  input logic en_b_i,
  input logic en_a_o,
  input logic en_a_oe_o,
  input logic en_b_o,
  input logic en_b_oe_o,
  input logic standby_o,
  input logic line_done_o
);

  logic start_pin;
  logic exit_pin;

  assign start_pin = fill_up_i ? en_a_i : en_b_i;
  assign exit_pin  = en_a_o | en_b_o;

  assert_start_wakes_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (standby_o && start_pin) |=> !standby_o);

  assert_pin_a_quiet_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_a_oe_o |-> !en_a_o);

  assert_pin_b_quiet_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_b_oe_o |-> !en_b_o);

  assert_exit_single_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    exit_pin |=> !exit_pin);

  assert_standby_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    (standby_o && !start_pin) |=> standby_o);

  assert_exit_active_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    exit_pin |-> !standby_o);

  assert_done_after_exit_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    line_done_o |-> $past(exit_pin));

endmodule

bind cad_column_capture cad_column_capture_chk i_chk (
  .clk_i       (clk_i),
  .rst_i       (rst_i),
  .fill_up_i   (fill_up_i),
  .en_a_i      (en_a_i),
  .en_b_i      (en_b_i),
  .en_a_o      (en_a_o),
  .en_a_oe_o   (en_a_oe_o),
  .en_b_o      (en_b_o),
  .en_b_oe_o   (en_b_oe_o),
  .standby_o   (standby_o),
  .line_done_o (line_done_o)
);

// File: tb/test_cad_column_capture.sv
`timescale 1ns/1ps
module test_cad_column_capture;

  localparam int G  = 4;
  localparam int W  = 18;
  localparam int LW = G * W;

  logic          clk = 1'b0;
  logic          rst;
  logic          fill_up;
  logic          en_a_i, en_b_i;
  logic          en_a_o, en_a_oe, en_b_o, en_b_oe;
  logic [W-1:0]  pix;
  logic [LW-1:0] line;
  logic          standby, done;

  logic [LW-1:0] exp_line;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cad_column_capture #(.GROUPS(G)) i_cad_column_capture (
    .clk_i        (clk),
    .rst_i        (rst),
    .fill_up_i    (fill_up),
    .en_a_i       (en_a_i),
    .en_b_i       (en_b_i),
    .en_a_o       (en_a_o),
    .en_a_oe_o    (en_a_oe),
    .en_b_o       (en_b_o),
    .en_b_oe_o    (en_b_oe),
    .pix_word_i   (pix),
    .line_codes_o (line),
    .standby_o    (standby),
    .line_done_o  (done)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mk_word(input logic [7:0] seed, input int k);
    logic [5:0] f0;
    f0 = seed[5:0] + 6'(3 * k);
    return {f0 + 6'd2, f0 + 6'd1, f0};
  endfunction

  task automatic drive_start(input logic up, input logic v);
    if (up) en_a_i = v; else en_b_i = v;
  endtask

  // Runs one full pass and compares every edge against the model.
  task automatic run_line(input logic up, input logic [7:0] seed, input logic hold_start);
    string line_req;
    line_req = up ? "R4" : "R5";
    @(negedge clk);
    fill_up = up;
    en_a_i = 1'b0; en_b_i = 1'b0;
    drive_start(up, 1'b1);
    pix = mk_word(seed, 0);
    for (int e = 0; e <= G; e++) begin
      @(posedge clk);
      @(negedge clk);
      if (e >= 1) begin
        int k, grp;
        k   = e - 1;
        grp = up ? k : G - 1 - k;
        exp_line[grp*W +: W] = mk_word(seed, k);
      end
      drive_start(up, hold_start && (e < G));
      pix = (e + 1 < G) ? mk_word(seed, e + 1) : '0;
      if (e == 0) check("R2 standby drops on start", 128'(standby), 128'(0));
      else        check("R7 standby during pass", 128'(standby), 128'(e == G));
      check(e == 2 ? "R11 unreached groups hold" : line_req, 128'(line), 128'(exp_line));
      check("R6 exit pulse", 128'(up ? en_b_o : en_a_o), 128'(e == G - 1));
      check("R6 input pin drives 0", 128'(up ? en_a_o : en_b_o), 128'(0));
      check("R9 done strobe", 128'(done), 128'(e == G));
      check(up ? "R4 pin roles" : "R5 pin roles", 128'({en_a_oe, en_b_oe}), 128'(up ? 2'b01 : 2'b10));
    end
    check("R3 field placement", 128'(line), 128'(exp_line));
    @(posedge clk);
    @(negedge clk);
    check("R9 done one cycle", 128'(done), 128'(0));
    check("R7 standby after pass", 128'(standby), 128'(1));
    check(hold_start ? "R8 retrigger ignored" : line_req, 128'(line), 128'(exp_line));
  endtask

  task automatic test_reset();
    check("R1 line zero", 128'(line), 128'(0));
    check("R1 standby", 128'(standby), 128'(1));
    check("R1 done", 128'(done), 128'(0));
    check("R1 enable outs", 128'({en_a_o, en_b_o}), 128'(0));
  endtask

  task automatic test_field_map();
    logic [W-1:0] w;
    run_line(1'b1, 8'h05, 1'b0);
    w = mk_word(8'h05, 0);
    check("R3 bits 5..0 lowest channel", 128'(line[5:0]), 128'(w[5:0]));
    check("R3 bits 11..6 middle channel", 128'(line[11:6]), 128'(w[11:6]));
    check("R3 bits 17..12 top channel", 128'(line[17:12]), 128'(w[17:12]));
  endtask

  task automatic test_wrong_pin(input logic up);
    @(negedge clk);
    fill_up = up;
    en_a_i = ~up; en_b_i = up;
    pix = 18'h3ffff;
    repeat (3) begin
      @(posedge clk);
      @(negedge clk);
      check("R10 output pin ignored: standby", 128'(standby), 128'(1));
      check("R10 output pin ignored: line", 128'(line), 128'(exp_line));
    end
    en_a_i = 1'b0; en_b_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; fill_up = 1'b1; en_a_i = 1'b0; en_b_i = 1'b0; pix = '0;
    exp_line = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_field_map();
    run_line(1'b0, 8'h21, 1'b0);
    run_line(1'b1, 8'h30, 1'b1);
    test_wrong_pin(1'b1);
    test_wrong_pin(1'b0);
    run_line(1'b0, 8'h0a, 1'b1);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule